// File: doc/BRIEF.md
# 24-Hour Time-of-Day Counter with Seven-Segment Digits

This block keeps the time of day from a single fast clock. A prescaler turns the input clock into a one-cycle enable once per second. Three cascaded counters hold seconds, minutes and hours. Seconds and minutes count modulo 60, and hours count modulo 24. All state runs on the input clock. The counters advance only through enables, so the design has no derived clocks.

The minute and hour values are each split into a tens digit and a units digit. Each digit drives its own 7-bit active-low segment pattern, giving a four-digit HH:MM readout. The prescaler also drives a square wave at one hertz. The binary minute and hour values come out as well, so a surrounding design can observe them. The only control input is a synchronous active-low reset, which starts the clock at midnight. The block has no way to set the time.

The parameter `CLK_HZ` sets the input clock rate, and with it the number of input cycles in one second. Its default is 27,000,000.

Top module: `tod_clock`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears the prescaler, seconds, minutes and hours to zero and drives `sec_wave` low. Out of reset, all four segment outputs show the digit 0, which is `7'b0000001`.
- R2: The seconds count advances once every `CLK_HZ` input cycles. After k rising edges following reset release, the elapsed time is floor(k / `CLK_HZ`) seconds.
- R3: `sec_wave` is low for the first `CLK_HZ/2` cycles of each second and high for the remaining cycles. After k edges it equals ((k mod `CLK_HZ`) >= `CLK_HZ/2`).
- R4: `min_bin` counts 0 to 59 and then wraps to 0. It advances only on the edge at which seconds wrap from 59 to 0, and it is stable on every other edge.
- R5: `hr_bin` counts 0 to 23 and then wraps to 0. It advances only on the edge at which minutes wrap from 59. The readout changes from 23:59 to 00:00 on the same edge at which seconds wrap.
- R6: Each displayed value is split into tens = value / 10 and units = value mod 10. For example, 13:47 shows the digits 1, 3, 4 and 7, and 10:00 shows 1, 0, 0 and 0.
- R7: Segment outputs are active-low, with bit 6 = segment a down to bit 0 = segment g. The digits 0 to 9 encode as:

  | Digit | Pattern |
  |---|---|
  | 0 | 0000001 |
  | 1 | 1001111 |
  | 2 | 0010010 |
  | 3 | 0000110 |
  | 4 | 1001100 |
  | 5 | 0100100 |
  | 6 | 0100000 |
  | 7 | 0001111 |
  | 8 | 0000000 |
  | 9 | 0000100 |

- R8: In the digit decoder `tod_seg_decoder`, any 4-bit code from 10 to 15 produces the error pattern `7'b1001001`.
- R9: A reset asserted in the middle of a run returns the time to 00:00:00 and restarts the one-second period from cycle zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock running at `CLK_HZ` |
| rst_n | input | 1 | Synchronous reset, active low |
| seg_hr_tens | output | 7 | Hours tens digit, active-low a..g |
| seg_hr_units | output | 7 | Hours units digit, active-low a..g |
| seg_min_tens | output | 7 | Minutes tens digit, active-low a..g |
| seg_min_units | output | 7 | Minutes units digit, active-low a..g |
| sec_wave | output | 1 | One-hertz square wave: low in the first half of each second, high in the second half |
| min_bin | output | 6 | Binary minutes, 0 to 59 |
| hr_bin | output | 5 | Binary hours, 0 to 23 |

## Verification
The clock runs with a two-cycle second and is carried through a full day. It is sampled just before and just after each carry boundary: the first minute, the first hour, and the 23:59 to 00:00 rollover. These samples tell a correct cascade apart from one that carries early, carries late, or wraps at the wrong modulus. Values such as 10:00, 13:47 and 20:00 exercise the digit split, where a zero tens digit and a non-zero tens digit behave differently. The standalone decoder is walked through all sixteen input codes, which separates the ten valid glyphs from the error glyph. A reset in the middle of the run, followed by a new minute boundary, shows that the prescaler phase is cleared along with the time.

// File: rtl/tod_pkg.sv
// Shared types and constants for the time-of-day counter.
// Assumes: segment buses are active-low with bit 6 = a ... bit 0 = g.
package tod_pkg;
    typedef logic [6:0] seg_t;
    typedef logic [3:0] bcd_t;

    localparam int   SEC_MOD   = 60;
    localparam int   MIN_MOD   = 60;
    localparam int   HR_MOD    = 24;
    localparam int   NUM_DIGIT = 4;
    localparam seg_t SEG_ERR   = 7'b1001001;
endpackage

// File: rtl/tod_prescaler.sv
// Prescaler: divides the input clock down to a one-cycle enable per second
// and a registered square wave that is low in the first half of each second.
// Assumes: CLK_HZ >= 2, and reset is synchronous and active low.
module tod_prescaler #(
    parameter int CLK_HZ = 27_000_000,
    parameter int CW     = (CLK_HZ > 2) ? $clog2(CLK_HZ) : 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick,
    output logic wave
);
    localparam logic [CW-1:0] LAST = CW'(CLK_HZ - 1);
    localparam logic [CW-1:0] HALF = CW'(CLK_HZ / 2);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nxt;

    // Purpose: next count, which returns to zero after the last cycle of a second.
    always_comb begin
        cnt_nxt = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    assign tick = (cnt_q == LAST);

    // Purpose: hold the cycle count and the registered half-period wave.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            wave  <= 1'b0;
        end else begin
            cnt_q <= cnt_nxt;
            wave  <= (cnt_nxt >= HALF);
        end
    end

    // R2: the count restarts right after the enable pulse.
    a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == '0));
    // R3: the wave is low at the start of every second.
    a_r3_low_first_half: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !wave);
    // R3: the wave goes high at the half point.
    a_r3_high_second_half: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == HALF - 1'b1) |=> wave);
endmodule

// File: rtl/tod_mod_counter.sv
// Enabled modulo counter for one time field. It raises wrap in the cycle in
// which an enable moves it from its last value back to zero.
// Assumes: MODULUS >= 2, and W is wide enough to hold MODULUS-1.
module tod_mod_counter #(
    parameter int MODULUS = 60,
    parameter int W       = $clog2(MODULUS)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    output logic [W-1:0] value,
    output logic         wrap
);
    localparam logic [W-1:0] LAST = W'(MODULUS - 1);

    // Purpose: step the field on enable, wrapping after LAST.
    always_ff @(posedge clk) begin
        if (!rst_n)
            value <= '0;
        else if (en)
            value <= (value == LAST) ? '0 : value + 1'b1;
    end

    assign wrap = en && (value == LAST);

    // R4: the field wraps to zero after its last value.
    a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (en && value == LAST) |=> (value == '0));
    // R4: the field holds when no enable arrives.
    a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(value));
    // R5: the field never leaves its range.
    a_r5_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        value <= LAST);
endmodule

// File: rtl/tod_digit_split.sv
// Splits a small binary value into a tens BCD digit and a units BCD digit.
// Assumes: value < 100, so the tens digit fits in four bits.
module tod_digit_split
    import tod_pkg::*;
#(
    parameter int W = 6
) (
    input  logic [W-1:0] value,
    output bcd_t         tens,
    output bcd_t         units
);
    // Purpose: divide and take the remainder by ten.
    always_comb begin
        tens  = 4'(32'(value) / 10);
        units = 4'(32'(value) % 10);
    end
endmodule

// File: rtl/tod_seg_decoder.sv
// Maps one BCD digit to an active-low a..g segment pattern. Codes above 9
// show the error glyph.
// Assumes: bit 6 of seg drives segment a.
module tod_seg_decoder
    import tod_pkg::*;
(
    input  bcd_t digit,
    output seg_t seg
);
    // Purpose: glyph lookup.
    always_comb begin
        unique case (digit)
            4'd0:    seg = 7'b0000001;
            4'd1:    seg = 7'b1001111;
            4'd2:    seg = 7'b0010010;
            4'd3:    seg = 7'b0000110;
            4'd4:    seg = 7'b1001100;
            4'd5:    seg = 7'b0100100;
            4'd6:    seg = 7'b0100000;
            4'd7:    seg = 7'b0001111;
            4'd8:    seg = 7'b0000000;
            4'd9:    seg = 7'b0000100;
            default: seg = SEG_ERR;
        endcase
    end
endmodule

// File: rtl/tod_clock.sv
// Top level of the time-of-day counter: prescaler, seconds/minutes/hours
// cascade, digit split and four segment decoders.
// Assumes: one clock domain, and a synchronous active-low reset to 00:00:00.
module tod_clock
    import tod_pkg::*;
#(
    parameter int CLK_HZ = 27_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic [6:0] seg_hr_tens,
    output logic [6:0] seg_hr_units,
    output logic [6:0] seg_min_tens,
    output logic [6:0] seg_min_units,
    output logic       sec_wave,
    output logic [5:0] min_bin,
    output logic [4:0] hr_bin
);
    localparam int SW = $clog2(SEC_MOD);
    localparam int MW = $clog2(MIN_MOD);
    localparam int HW = $clog2(HR_MOD);

    logic          tick;
    logic          sec_wrap;
    logic          min_wrap;
    logic          hr_wrap;
    logic [SW-1:0] sec_q;
    logic [MW-1:0] min_q;
    logic [HW-1:0] hr_q;
    bcd_t          digits [NUM_DIGIT];
    seg_t          segs   [NUM_DIGIT];

    tod_prescaler #(.CLK_HZ(CLK_HZ)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wave(sec_wave)
    );

    tod_mod_counter #(.MODULUS(SEC_MOD), .W(SW)) u_sec (
        .clk(clk), .rst_n(rst_n), .en(tick), .value(sec_q), .wrap(sec_wrap)
    );
    tod_mod_counter #(.MODULUS(MIN_MOD), .W(MW)) u_min (
        .clk(clk), .rst_n(rst_n), .en(sec_wrap), .value(min_q), .wrap(min_wrap)
    );
    tod_mod_counter #(.MODULUS(HR_MOD), .W(HW)) u_hr (
        .clk(clk), .rst_n(rst_n), .en(min_wrap), .value(hr_q), .wrap(hr_wrap)
    );

    // Digit order in the arrays: 0 = hour tens, 1 = hour units,
    // 2 = minute tens, 3 = minute units.
    tod_digit_split #(.W(HW)) u_hr_split (
        .value(hr_q), .tens(digits[0]), .units(digits[1])
    );
    tod_digit_split #(.W(MW)) u_min_split (
        .value(min_q), .tens(digits[2]), .units(digits[3])
    );

    for (genvar d = 0; d < NUM_DIGIT; d++) begin : g_dec
        tod_seg_decoder u_dec (.digit(digits[d]), .seg(segs[d]));
    end

    assign seg_hr_tens   = segs[0];
    assign seg_hr_units  = segs[1];
    assign seg_min_tens  = segs[2];
    assign seg_min_units = segs[3];
    assign min_bin       = min_q;
    assign hr_bin        = hr_q;

    // R5: each minute wrap moves the hour forward by one, modulo 24.
    a_r5_hour_step: assert property (@(posedge clk) disable iff (!rst_n)
        min_wrap |=> (hr_bin == (($past(hr_bin) == 5'd23) ? 5'd0 : $past(hr_bin) + 5'd1)));
    // R4: the minute changes only when seconds wrap.
    a_r4_min_only_on_carry: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_wrap |=> $stable(min_bin));
    // R5: the hour wraps only from 23.
    a_r5_hour_wrap_from_23: assert property (@(posedge clk) disable iff (!rst_n)
        hr_wrap |-> (hr_bin == 5'd23 && min_bin == 6'd59));
endmodule

// File: tb/tod_clock_test.sv
module tod_clock_test;
    localparam int N = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] s_ht, s_hu, s_mt, s_mu;
    logic       wave;
    logic [5:0] mb;
    logic [4:0] hb;
    logic [3:0] probe_in = 4'd0;
    logic [6:0] probe_seg;

    int checks = 0;
    int fails  = 0;
    longint k  = 0;
    bit done   = 1'b0;

    // Decoder table: index = code, value = expected pattern (R7, R8).
    localparam logic [6:0] GLYPH [16] = '{
        7'b0000001, 7'b1001111, 7'b0010010, 7'b0000110,
        7'b1001100, 7'b0100100, 7'b0100000, 7'b0001111,
        7'b0000000, 7'b0000100, 7'b1001001, 7'b1001001,
        7'b1001001, 7'b1001001, 7'b1001001, 7'b1001001
    };

    always #2 clk = ~clk;

    tod_clock #(.CLK_HZ(N)) uut (
        .clk(clk), .rst_n(rst_n),
        .seg_hr_tens(s_ht), .seg_hr_units(s_hu),
        .seg_min_tens(s_mt), .seg_min_units(s_mu),
        .sec_wave(wave), .min_bin(mb), .hr_bin(hb)
    );

    tod_seg_decoder dec_probe (.digit(probe_in), .seg(probe_seg));

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, exp, k);
        end
    endtask

    task automatic advance(input longint target);
        while (k < target) begin
            @(posedge clk);
            k++;
        end
        @(negedge clk);
    endtask

    task automatic check_time(input string req);
        longint s = k / N;
        int m = int'((s / 60) % 60);
        int h = int'((s / 3600) % 24);
        chk({req, " min_bin"}, mb, m);
        chk({req, " hr_bin"}, hb, h);
        chk({req, " R6/R7 hr tens"}, s_ht, GLYPH[h / 10]);
        chk({req, " R6/R7 hr units"}, s_hu, GLYPH[h % 10]);
        chk({req, " R6/R7 min tens"}, s_mt, GLYPH[m / 10]);
        chk({req, " R6/R7 min units"}, s_mu, GLYPH[m % 10]);
        chk({req, " R3 wave"}, wave, ((k % N) >= N / 2) ? 1 : 0);
    endtask

    initial begin
        repeat (195_000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // Decoder table walk (R7 codes 0-9, R8 codes 10-15)
        for (int c = 0; c < 16; c++) begin
            probe_in = 4'(c);
            #1;
            chk((c < 10) ? "R7 glyph" : "R8 error glyph", probe_seg, GLYPH[c]);
        end

        // R1 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 wave", wave, 0);
        check_time("R1");
        rst_n = 1'b1;

        // R2/R3 prescaler phases
        advance(1);  check_time("R3 k1");
        advance(2);  check_time("R3 k2");
        // R4 first minute boundary
        advance(119); check_time("R4 before");
        advance(120); check_time("R4 after");
        // R5 first hour boundary
        advance(7199); check_time("R5 before");
        advance(7200); check_time("R5 after");
        // R6 10:00, 13:47, 20:00
        advance(72000);  check_time("R6 10:00");
        advance(99240);  check_time("R6 13:47");
        advance(144000); check_time("R6 20:00");
        // R5 day rollover
        advance(172798); check_time("R5 23:59");
        advance(172799); check_time("R5 23:59 last");
        advance(172800); check_time("R5 00:00");
        chk("R5 rollover hour", hb, 0);
        advance(172921); check_time("R2 next day");

        // R9 mid-run reset
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        k = 0;
        check_time("R9 reset");
        chk("R9 hr", hb, 0);
        advance(119); check_time("R9 phase before");
        advance(120); check_time("R9 phase after");
        chk("R9 min", mb, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule